// File: doc/BRIEF.md
# UART Receive Channel with Sticky Status

This block is the receive half of one asynchronous serial channel, together with its control and status logic. A shifter oversamples the serial line at 16 clocks per bit and samples each bit at its mid-point. It can take frames with eight data bits and no parity, even parity or odd parity, followed by one stop bit. A finished byte moves into a data register and sets a buffer-full flag. The block also records parity, framing and overrun errors as sticky flags.

Software reaches the block through a four-word register bus. One word returns the received byte, and reading it empties the buffer. One word returns the status. One word is a write-one-to-clear trigger for the error flags. One word holds a pair of start and stop triggers, which set or clear the channel-enable bit. Error flags change only through the clear trigger. The intended service sequence is to read the data, read the status, and write that status value back to the clear trigger. This sequence cannot erase an error that was raised after the status read.

Top module: `uart_rx_status`

## Requirements
- R1: A frame is received as a low start bit, eight data bits with the least significant bit first, an optional parity bit, and one stop bit. Each bit lasts 16 clocks. The byte then appears at bus address 0, and status bit 3 (buffer full) is set. Status is read at address 1.
- R2: The parity mode is selected by par_mode_i: 0 means no parity bit, 1 means even parity, 2 means odd parity. When the received parity bit does not match, status bit 0 (parity error) is set.
- R3: A stop bit sampled as 0 sets status bit 1 (framing error). The byte is still stored and buffer full is still set.
- R4: A bus read of address 0 clears buffer full, so the next byte can be accepted.
- R5: A frame that completes while buffer full is set sets status bit 2 (overrun). The data register keeps the older byte, the new byte is discarded, and the parity and framing flags are not updated by that frame.
- R6: A write to address 2 clears each error flag whose bit (bit 0 parity, bit 1 framing, bit 2 overrun) is 1 and leaves flags written as 0 unchanged. Writing back an earlier status value does not clear an error raised after that status was read. If an error is raised in the same cycle as its clear, the error stays set.
- R7: At address 3, writing 1 to bit 0 sets status bit 4 (channel enabled), and writing 1 to bit 1 clears it. If both bits are 1, stop takes priority. While the channel is stopped, no frame is received. Stopping the channel sends the shifter back to idle, so a frame cut off by the stop is never completed.
- R8: A low pulse on the line that has ended before the start bit's mid-point is ignored.
- R9: After reset, all status bits are 0, the data register is 0, and the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, 16 ticks per bit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial receive line, idle high |
| par_mode_i | input | 2 | Parity mode: 0 none, 1 even, 2 odd |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Bus access is a write when set |
| bus_addr_i | input | 2 | Register address: 0 data, 1 status, 2 clear trigger, 3 start/stop |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational |

## Verification
The test covers reception in three ways. It sends all 256 byte values with no parity. It sends a set of bytes in even mode and in odd mode, with the parity bit alternating between correct and wrong; this separates the two parity polarities and shows the data path still works when the parity bit is bad. Separate frame patterns cover the remaining cases. One frame has a stop bit of 0. Two frames arrive back to back with no read between them (overrun). One frame has a framing error that arrives after the status was read, which shows the difference between clearing by snapshot and clearing everything. A short low glitch is sent, and a frame is cut off by a stop and then followed by a clean frame once the channel is started again. One frame is sent while the channel is stopped, and one write sets start and stop together.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_state_e;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CLR  = 2'd2;
  localparam logic [1:0] ADDR_RUN  = 2'd3;

  localparam int BIT_PERR = 0;
  localparam int BIT_FERR = 1;
  localparam int BIT_OVR  = 2;
  localparam int BIT_FULL = 3;
  localparam int BIT_EN   = 4;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rx_i,
  input  logic [1:0]        par_mode_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              par_err_o,
  output logic              frm_err_o
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  logic [1:0]        sync_q;
  logic              rx_s;
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shift_q;
  logic              par_bad_q;
  logic              par_en;

  assign rx_s   = sync_q[1];
  assign par_en = (par_mode_i == PAR_EVEN) || (par_mode_i == PAR_ODD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shift_q   <= '0;
      par_bad_q <= 1'b0;
      done_o    <= 1'b0;
      data_o    <= '0;
      par_err_o <= 1'b0;
      frm_err_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          ST_IDLE: if (!rx_s) begin
            state_q   <= ST_START;
            cnt_q     <= '0;
            par_bad_q <= 1'b0;
          end
          ST_START: if (cnt_q == CNT_HALF) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= rx_s ? ST_IDLE : ST_DATA;  // high at mid-point: glitch
          end else cnt_q <= cnt_q + 1'b1;
          ST_DATA: if (cnt_q == CNT_FULL) begin
            cnt_q   <= '0;
            shift_q <= {rx_s, shift_q[DATA_W-1:1]};
            idx_q   <= idx_q + 1'b1;
            if (idx_q == IDX_LAST) state_q <= par_en ? ST_PAR : ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          ST_PAR: if (cnt_q == CNT_FULL) begin
            cnt_q     <= '0;
            par_bad_q <= rx_s ^ (^shift_q) ^ (par_mode_i == PAR_ODD);
            state_q   <= ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
          ST_STOP: if (cnt_q == CNT_FULL) begin
            cnt_q     <= '0;
            done_o    <= 1'b1;
            data_o    <= shift_q;
            par_err_o <= par_bad_q;
            frm_err_o <= !rx_s;
            state_q   <= ST_IDLE;
          end else cnt_q <= cnt_q + 1'b1;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  a_r7_idle_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ST_IDLE);
  a_r8_data_needs_low_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && en_i && rx_s) |=> state_q != ST_DATA);
  a_r1_done_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q == ST_STOP));
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_perr_i,
  input  logic              rx_ferr_i,
  input  logic              data_rd_i,
  input  logic              clr_we_i,
  input  logic [2:0]        clr_mask_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              perr_o,
  output logic              ferr_o,
  output logic              ovr_o,
  output logic              en_o
);
  logic accept, ovr_set;

  assign accept  = rx_done_i && !full_o;
  assign ovr_set = rx_done_i && full_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      ovr_o  <= 1'b0;
      en_o   <= 1'b0;
    end else begin
      if (accept) data_o <= rx_data_i;

      if (accept)         full_o <= 1'b1;
      else if (data_rd_i) full_o <= 1'b0;

      // set beats clear
      if (accept && rx_perr_i)            perr_o <= 1'b1;
      else if (clr_we_i && clr_mask_i[0]) perr_o <= 1'b0;

      if (accept && rx_ferr_i)            ferr_o <= 1'b1;
      else if (clr_we_i && clr_mask_i[1]) ferr_o <= 1'b0;

      if (ovr_set)                        ovr_o <= 1'b1;
      else if (clr_we_i && clr_mask_i[2]) ovr_o <= 1'b0;

      if (stop_i)       en_o <= 1'b0;
      else if (start_i) en_o <= 1'b1;
    end
  end

  a_r4_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd_i && !rx_done_i) |=> !full_o);
  a_r5_overrun_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && full_o) |=> ovr_o);
  a_r5_old_byte_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && full_o) |=> $stable(data_o));
  a_r6_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && !full_o && rx_ferr_i && clr_we_i && clr_mask_i[1]) |=> ferr_o);
  a_r6_zero_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_o && !(clr_we_i && clr_mask_i[2])) |=> ovr_o);
  a_r7_stop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !en_o);
  a_r7_start_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> en_o);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  input  logic [1:0]        par_mode_i,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  logic              rx_done, rx_perr, rx_ferr;
  logic [DATA_W-1:0] rx_byte, data_q;
  logic              full, perr, ferr, ovr, chan_en;
  logic              data_rd, clr_we, run_we;
  logic [DATA_W-1:0] stat;
  logic              unused_wdata;

  assign data_rd      = bus_sel_i && !bus_we_i && (bus_addr_i == ADDR_DATA);
  assign clr_we       = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_CLR);
  assign run_we       = bus_sel_i && bus_we_i && (bus_addr_i == ADDR_RUN);
  assign unused_wdata = ^bus_wdata_i[DATA_W-1:3];

  uart_rx_shifter #(.OVS(OVS), .DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .en_i      (chan_en),
    .rx_i,
    .par_mode_i,
    .done_o    (rx_done),
    .data_o    (rx_byte),
    .par_err_o (rx_perr),
    .frm_err_o (rx_ferr)
  );

  uart_rx_flags #(.DATA_W(DATA_W)) u_flags (
    .clk_i, .rst_ni,
    .rx_done_i  (rx_done),
    .rx_data_i  (rx_byte),
    .rx_perr_i  (rx_perr),
    .rx_ferr_i  (rx_ferr),
    .data_rd_i  (data_rd),
    .clr_we_i   (clr_we),
    .clr_mask_i (bus_wdata_i[2:0]),
    .start_i    (run_we && bus_wdata_i[0]),
    .stop_i     (run_we && bus_wdata_i[1]),
    .data_o     (data_q),
    .full_o     (full),
    .perr_o     (perr),
    .ferr_o     (ferr),
    .ovr_o      (ovr),
    .en_o       (chan_en)
  );

  always_comb begin
    stat           = '0;
    stat[BIT_PERR] = perr;
    stat[BIT_FERR] = ferr;
    stat[BIT_OVR]  = ovr;
    stat[BIT_FULL] = full;
    stat[BIT_EN]   = chan_en;
  end

  always_comb begin
    case (bus_addr_i)
      ADDR_DATA: bus_rdata_o = data_q;
      ADDR_STAT: bus_rdata_o = stat;
      default:   bus_rdata_o = '0;
    endcase
  end

  a_r9_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done) |-> chan_en || $past(chan_en));
endmodule

// File: tb/uart_rx_status_test.sv
`timescale 1ns/1ps
module uart_rx_status_test;
  localparam int OVS = 16;
  localparam int DW  = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          rx = 1'b1;
  logic [1:0]    pmode = 2'd0;
  logic          sel = 1'b0, we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  int            n_chk = 0, n_bad = 0;
  bit            finished = 1'b0;

  always #10 clk = ~clk;

  uart_rx_status #(.OVS(OVS), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx), .par_mode_i(pmode),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #2 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    rx = b;
    repeat (OVS) @(negedge clk);
  endtask

  // par_flip: send the wrong parity bit; stop_v: stop bit level
  task automatic send_frame(input logic [7:0] b, input logic par_flip, input logic stop_v);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    if (pmode == 2'd1) send_bit((^b) ^ par_flip);
    if (pmode == 2'd2) send_bit((~^b) ^ par_flip);
    send_bit(stop_v);
    rx = 1'b1;
    repeat (2 * OVS) @(negedge clk);
  endtask

  initial begin
    #(20.0 * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d, s;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    bus_rd(2'd1, d); check("R9 status after reset", d, 8'h00);
    bus_rd(2'd0, d); check("R9 data after reset", d, 8'h00);

    // R7 stopped channel ignores a frame
    send_frame(8'h6E, 1'b0, 1'b1);
    bus_rd(2'd1, d); check("R7 no reception while stopped", d, 8'h00);
    bus_wr(2'd3, 8'h01);
    bus_rd(2'd1, d); check("R7 start sets enable", d, 8'h10);

    // R1/R4 full byte sweep, no parity
    for (int b = 0; b < 256; b++) begin
      send_frame(8'(b), 1'b0, 1'b1);
      bus_rd(2'd1, d); check("R1 status after frame", d, 8'h18);
      bus_rd(2'd0, d); check("R1 received byte", d, b);
      bus_rd(2'd1, d); check("R4 read empties buffer", d, 8'h10);
    end

    // R2 even and odd parity, alternating good and bad parity bit
    for (int m = 1; m <= 2; m++) begin
      pmode = 2'(m);
      for (int i = 0; i < 32; i++) begin
        logic [7:0] b;
        logic       flip;
        b    = 8'(i * 37 + m * 11);
        flip = i[0];
        send_frame(b, flip, 1'b1);
        bus_rd(2'd1, d); check("R2 parity status", d, 8'h18 | {7'd0, flip});
        bus_rd(2'd0, d); check("R2 byte with parity", d, b);
        if (flip) bus_wr(2'd2, 8'h01);
        bus_rd(2'd1, d); check("R6 parity flag cleared", d, 8'h10);
      end
    end
    pmode = 2'd0;

    // R3 framing error keeps byte
    send_frame(8'h81, 1'b0, 1'b0);
    bus_rd(2'd1, d); check("R3 framing flag and full", d, 8'h1A);
    bus_rd(2'd0, d); check("R3 byte stored", d, 8'h81);
    bus_wr(2'd2, 8'h02);
    bus_rd(2'd1, d); check("R6 framing cleared", d, 8'h10);

    // R5 overrun
    send_frame(8'h5A, 1'b0, 1'b1);
    send_frame(8'hA5, 1'b0, 1'b0);
    bus_rd(2'd1, d); check("R5 overrun flagged, no framing", d, 8'h1C);
    bus_rd(2'd0, d); check("R5 old byte kept", d, 8'h5A);
    bus_rd(2'd1, s); check("R5 status snapshot", s, 8'h14);

    // R6 newer error survives write-back of snapshot
    send_frame(8'h33, 1'b0, 1'b0);
    bus_rd(2'd1, d); check("R3 new framing error", d, 8'h1E);
    bus_wr(2'd2, s);
    bus_rd(2'd1, d); check("R6 only snapshot errors cleared", d, 8'h1A);
    bus_wr(2'd2, 8'h00);
    bus_rd(2'd1, d); check("R6 zero write leaves flags", d, 8'h1A);
    bus_wr(2'd2, 8'h02);
    bus_rd(2'd1, d); check("R6 framing cleared", d, 8'h18);
    bus_rd(2'd0, d); check("R3 framing byte", d, 8'h33);

    // R8 glitch rejection
    rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (3 * OVS) @(negedge clk);
    bus_rd(2'd1, d); check("R8 glitch ignored", d, 8'h10);

    // R7 stop mid-frame, then clean frame
    send_bit(1'b0);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    bus_wr(2'd3, 8'h02);
    rx = 1'b1; repeat (2 * OVS) @(negedge clk);
    bus_rd(2'd1, d); check("R7 stop clears enable", d, 8'h00);
    bus_wr(2'd3, 8'h01);
    send_frame(8'hC3, 1'b0, 1'b1);
    bus_rd(2'd1, d); check("R7 cut frame dropped", d, 8'h18);
    bus_rd(2'd0, d); check("R7 clean frame after restart", d, 8'hC3);

    // R7 stop wins over start
    bus_wr(2'd3, 8'h03);
    bus_rd(2'd1, d); check("R7 stop priority", d, 8'h00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule